// File: doc/BRIEF.md
# Main Clock Source Switch Controller

This block decides which source clocks the CPU of a small microcontroller. After reset the CPU runs from the internal high-speed oscillator. Software can move the CPU clock to a crystal oscillator or to an external clock input. It does this through a small byte-wide register bus. The registers are:

- a mode register that can be written once;
- a stabilization-time select;
- an oscillator stop bit;
- a read-only stabilization status;
- a clock select bit.

The block drives the enables of the oscillator pad. It counts oscillator cycles to measure start-up time, and it drives two gate enables that feed a glitch-free clock multiplexer.

The stabilization counter runs on the oscillator clock. It reports a thermometer code that is synchronized bit by bit into the bus clock domain. When the crystal is the chosen source, a request to switch is held pending until the chosen threshold has been reached. When the external input is the chosen source, the request is granted without that check. The granted request passes through a two-flop synchronizer. It then reaches the gate enables in break-before-make order: the old enable drops before the new one rises.

Top module: `clksw_top`

## Requirements
- R1: After reset the internal gate enable is 1 and the main gate enable is 0. The mode register (address 0) reads 0, the stop bit (address 2, bit 0) reads 1, the select register (address 3) reads 0, the status (addresses 4 and 5) reads 0, and the oscillator pad enables are 0.
- R2: The mode register has three bits: bit 0 selects the external input (1) or the crystal (0), bit 1 enables the main oscillator pin function, and bit 2 selects the high crystal range. The register takes only the first write made with the full-byte strobe set. A write without the strobe is ignored and does not use up that one write. Every later write is ignored.
- R3: `xtal_en` is 1 exactly when pin function = 1, external = 0 and stop = 0. `extclk_en` is 1 exactly when pin function = 1, external = 1 and stop = 0. `amp_hi` follows mode bit 2 but is forced to 0 while external = 1.
- R4: While stop = 0 the counter counts oscillator cycles. Status bit i becomes 1 once 2^(MIN_EXP+i) cycles have been counted. Bits 7:0 read at address 4 and the higher bits at address 5. Writes to the status addresses are ignored.
- R5: Address 1 bits 3:0 hold the threshold index. A value above NUM_THR-1 is stored and read back as NUM_THR-1.
- R6: With the crystal chosen, writing 1 to address 3 bit 0 sets a request (read back at bit 0). The request is held pending until status bit [index] is set. Address 3 bit 1 reads 1 while the main gate is enabled.
- R7: With the external input chosen, the request is granted without waiting for any status bit.
- R8: The two gate enables are never both 1. On a switch the old enable falls at least one cycle before the new one rises.
- R9: Writing 1 to the stop bit clears the counter and the status. That write is ignored while a switch to the main source is granted or the main gate is enabled.
- R10: Writing 0 to address 3 bit 0 returns the CPU clock to the internal oscillator.
- R11: With the pin function bit at 0, a request is never granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and control clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| osc_clk | input | 1 | Main oscillator clock, used by the stabilization counter |
| bus_wr | input | 1 | Write strobe |
| bus_full | input | 1 | 1 for a full-byte write, 0 for a partial write |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| xtal_en | output | 1 | Crystal oscillator enable |
| extclk_en | output | 1 | External clock input enable |
| amp_hi | output | 1 | Crystal high-range selection |
| gate_int_en | output | 1 | Multiplexer gate enable, internal oscillator |
| gate_main_en | output | 1 | Multiplexer gate enable, main source |

## Verification
The assertions assume four things about the inputs:

- `osc_clk` toggles whenever the stop bit is 0, so status bits appear and stay set.
- Bus writes are single-cycle pulses with stable address and data.
- Reset is applied before any bus activity.
- The stop bit is not set and cleared again so fast that the oscillator side never sees it.

The stimulus keeps within these assumptions. It runs a free-running oscillator at a period unrelated to the bus clock and issues one write at a time between falling edges. It also leaves many bus cycles between each stop change and the checks that follow it.

// File: rtl/clksw_pkg.sv
package clksw_pkg;
  localparam logic [2:0] A_MODE    = 3'd0;
  localparam logic [2:0] A_STSEL   = 3'd1;
  localparam logic [2:0] A_STOP    = 3'd2;
  localparam logic [2:0] A_SEL     = 3'd3;
  localparam logic [2:0] A_STAT_LO = 3'd4;
  localparam logic [2:0] A_STAT_HI = 3'd5;

  // mode register: bit2 high range, bit1 pin function, bit0 external input
  typedef struct packed {
    logic amp_hi;
    logic osel;
    logic ext;
  } mode_t;
endpackage

// File: rtl/clksw_stab_counter.sv
module clksw_stab_counter #(
  parameter int MIN_EXP = 8,
  parameter int NUM_THR = 11
) (
  input  logic               osc_clk,
  input  logic               clk,
  input  logic               rst_n,
  input  logic               stop_i,
  output logic [NUM_THR-1:0] thermo_o
);
  localparam int CW = MIN_EXP + NUM_THR;

  logic               stop_s1, stop_s2;
  logic [CW-1:0]      cnt_q;
  logic [NUM_THR-1:0] thermo_osc;
  logic [NUM_THR-1:0] sync_a, sync_b;

  // stop request into the oscillator domain
  always_ff @(posedge osc_clk or negedge rst_n) begin
    if (!rst_n) begin
      stop_s1 <= 1'b1;
      stop_s2 <= 1'b1;
    end else begin
      stop_s1 <= stop_i;
      stop_s2 <= stop_s1;
    end
  end

  // saturating cycle counter: stops once the top threshold bit is reached
  always_ff @(posedge osc_clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (stop_s2)        cnt_q <= '0;
    else if (!cnt_q[CW-1])   cnt_q <= cnt_q + 1'b1;
  end

  // one thermometer flop per threshold
  for (genvar i = 0; i < NUM_THR; i++) begin : g_thr
    always_ff @(posedge osc_clk or negedge rst_n) begin
      if (!rst_n)       thermo_osc[i] <= 1'b0;
      else if (stop_s2) thermo_osc[i] <= 1'b0;
      else              thermo_osc[i] <= |cnt_q[CW-1:MIN_EXP+i];
    end
  end

  // each bit is monotonic while counting, so per-bit synchronizers are safe
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_a <= '0;
      sync_b <= '0;
    end else if (stop_i) begin
      sync_a <= '0;
      sync_b <= '0;
    end else begin
      sync_a <= thermo_osc;
      sync_b <= sync_a;
    end
  end

  assign thermo_o = sync_b;
endmodule

// File: rtl/clksw_bbm.sv
module clksw_bbm (
  input  logic clk,
  input  logic rst_n,
  input  logic want_main_i,
  output logic en_int_o,
  output logic en_main_o
);
  logic s1, s2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 1'b0;
      s2 <= 1'b0;
    end else begin
      s1 <= want_main_i;
      s2 <= s1;
    end
  end

  // break first, make on the following cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_int_o  <= 1'b1;
      en_main_o <= 1'b0;
    end else if (s2) begin
      if (en_int_o)        en_int_o  <= 1'b0;
      else if (!en_main_o) en_main_o <= 1'b1;
    end else begin
      if (en_main_o)       en_main_o <= 1'b0;
      else if (!en_int_o)  en_int_o  <= 1'b1;
    end
  end
endmodule

// File: rtl/clksw_regs.sv
module clksw_regs
  import clksw_pkg::*;
#(
  parameter int NUM_THR = 11
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic        wr_full,
  input  logic [2:0]  addr,
  input  logic [7:0]  wdata,
  input  logic        stable_i,
  input  logic [15:0] status_i,
  input  logic        main_active_i,
  output mode_t       mode_o,
  output logic        locked_o,
  output logic [3:0]  stsel_o,
  output logic        stop_o,
  output logic        grant_o,
  output logic [7:0]  rdata_o
);
  localparam logic [3:0] MAX_IDX = 4'(NUM_THR - 1);

  mode_t      mode_q;
  logic       locked_q, stop_q, req_q, grant_q;
  logic [3:0] stsel_q, sel_clamped;
  logic       ok, main_busy;

  assign sel_clamped = (wdata[3:0] > MAX_IDX) ? MAX_IDX : wdata[3:0];
  assign main_busy   = grant_q | main_active_i;
  assign ok          = req_q & mode_q.osel & ~stop_q & (mode_q.ext | stable_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= '0;
      locked_q <= 1'b0;
      stsel_q  <= '0;
      stop_q   <= 1'b1;
      req_q    <= 1'b0;
      grant_q  <= 1'b0;
    end else begin
      grant_q <= req_q & (grant_q | ok);
      if (wr_en) begin
        case (addr)
          A_MODE: if (wr_full && !locked_q) begin
            mode_q   <= mode_t'(wdata[2:0]);
            locked_q <= 1'b1;
          end
          A_STSEL: stsel_q <= sel_clamped;
          A_STOP:  if (!(wdata[0] && main_busy)) stop_q <= wdata[0];
          A_SEL:   req_q <= wdata[0];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (addr)
      A_MODE:    rdata_o = {5'b0, mode_q};
      A_STSEL:   rdata_o = {4'b0, stsel_q};
      A_STOP:    rdata_o = {7'b0, stop_q};
      A_SEL:     rdata_o = {6'b0, main_active_i, req_q};
      A_STAT_LO: rdata_o = status_i[7:0];
      A_STAT_HI: rdata_o = status_i[15:8];
      default:   rdata_o = 8'h00;
    endcase
  end

  assign mode_o   = mode_q;
  assign locked_o = locked_q;
  assign stsel_o  = stsel_q;
  assign stop_o   = stop_q;
  assign grant_o  = grant_q;
endmodule

// File: rtl/clksw_top.sv
module clksw_top
  import clksw_pkg::*;
#(
  parameter int MIN_EXP = 8,
  parameter int NUM_THR = 11
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       osc_clk,
  input  logic       bus_wr,
  input  logic       bus_full,
  input  logic [2:0] bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic       xtal_en,
  output logic       extclk_en,
  output logic       amp_hi,
  output logic       gate_int_en,
  output logic       gate_main_en
);
  localparam int PAD = 16 - NUM_THR;

  mode_t              mode;
  logic               locked, stop, grant, stable;
  logic [3:0]         stsel;
  logic [NUM_THR-1:0] thermo;
  logic [15:0]        status16;

  assign status16 = {{PAD{1'b0}}, thermo};
  assign stable   = status16[stsel];

  clksw_regs #(.NUM_THR(NUM_THR)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(bus_wr), .wr_full(bus_full),
    .addr(bus_addr), .wdata(bus_wdata), .stable_i(stable),
    .status_i(status16), .main_active_i(gate_main_en),
    .mode_o(mode), .locked_o(locked), .stsel_o(stsel), .stop_o(stop),
    .grant_o(grant), .rdata_o(bus_rdata)
  );

  clksw_stab_counter #(.MIN_EXP(MIN_EXP), .NUM_THR(NUM_THR)) u_cnt (
    .osc_clk(osc_clk), .clk(clk), .rst_n(rst_n), .stop_i(stop),
    .thermo_o(thermo)
  );

  clksw_bbm u_bbm (
    .clk(clk), .rst_n(rst_n), .want_main_i(grant),
    .en_int_o(gate_int_en), .en_main_o(gate_main_en)
  );

  assign xtal_en   = mode.osel & ~mode.ext & ~stop;
  assign extclk_en = mode.osel &  mode.ext & ~stop;
  assign amp_hi    = mode.amp_hi & ~mode.ext;
endmodule

// File: rtl/clksw_checker.sv
module clksw_checker (
  input logic        clk,
  input logic        rst_n,
  input logic [2:0]  mode_bits,
  input logic        locked,
  input logic        stop,
  input logic        grant,
  input logic        stable,
  input logic [15:0] status,
  input logic        en_int,
  input logic        en_main
);
  assert_mode_frozen_R2: assert property (@(posedge clk) disable iff (!rst_n)
    locked && $past(locked) |-> $stable(mode_bits));

  assert_gates_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({en_int, en_main}));

  assert_make_after_break_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(en_main) |-> !en_int && !$past(en_int));

  // grant needs pin function and either external input or a stable crystal
  assert_grant_gated_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(grant) |-> $past(mode_bits[1] && (mode_bits[0] || stable)));

  assert_no_stop_while_main_R9: assert property (@(posedge clk) disable iff (!rst_n)
    en_main |-> !stop);

  assert_status_cleared_R9: assert property (@(posedge clk) disable iff (!rst_n)
    stop && $past(stop) |-> status == 16'h0);
endmodule

bind clksw_top clksw_checker u_chk (
  .clk(clk), .rst_n(rst_n), .mode_bits(mode), .locked(locked),
  .stop(stop), .grant(grant), .stable(stable), .status(status16),
  .en_int(gate_int_en), .en_main(gate_main_en)
);

// File: tb/clksw_top_test.sv
module clksw_top_test;
  localparam int PERIOD     = 10;
  localparam int OSC_PERIOD = 14;
  localparam int NVEC       = 7;

  // vector: {addr[2:0], wdata[7:0], full, expected readback[7:0]}
  localparam logic [19:0] VEC [NVEC] = '{
    {3'd0, 8'h06, 1'b0, 8'h00},  // R2 partial write ignored
    {3'd0, 8'h02, 1'b1, 8'h02},  // R2 first full write taken
    {3'd0, 8'h07, 1'b1, 8'h02},  // R2 second write ignored
    {3'd1, 8'h09, 1'b1, 8'h03},  // R5 clamp to NUM_THR-1
    {3'd1, 8'h02, 1'b1, 8'h02},  // R5 in range
    {3'd4, 8'hFF, 1'b1, 8'h00},  // R4 status not writable
    {3'd2, 8'h00, 1'b1, 8'h00}   // stop cleared
  };

  logic clk = 0, osc_clk = 0, rst_n = 0;
  logic bus_wr = 0, bus_full = 0;
  logic [2:0] bus_addr = 0;
  logic [7:0] bus_wdata = 0, bus_rdata;
  logic xtal_en, extclk_en, amp_hi, gate_int_en, gate_main_en;
  int errors = 0, checks = 0;
  logic done = 0;

  always #(PERIOD/2) clk = ~clk;
  always #(OSC_PERIOD/2) osc_clk = ~osc_clk;

  clksw_top #(.MIN_EXP(3), .NUM_THR(4)) uut (
    .clk(clk), .rst_n(rst_n), .osc_clk(osc_clk), .bus_wr(bus_wr),
    .bus_full(bus_full), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .xtal_en(xtal_en), .extclk_en(extclk_en),
    .amp_hi(amp_hi), .gate_int_en(gate_int_en), .gate_main_en(gate_main_en)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d, input logic full);
    @(negedge clk);
    bus_wr = 1; bus_addr = a; bus_wdata = d; bus_full = full;
    @(negedge clk);
    bus_wr = 0; bus_full = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic do_reset();
    rst_n = 0; bus_wr = 0; bus_full = 0; bus_addr = 0; bus_wdata = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic wait_main(input logic target, input int maxc, output int n);
    n = 0;
    while (gate_main_en !== target && n < maxc) begin
      @(negedge clk);
      n++;
    end
  endtask

  initial begin
    #(PERIOD * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    int n;
    do_reset();
    // R1 reset state
    rd(3'd0, v); chk("R1 mode", v, 8'h00);
    rd(3'd2, v); chk("R1 stop", v, 8'h01);
    rd(3'd3, v); chk("R1 sel", v, 8'h00);
    rd(3'd4, v); chk("R1 status", v, 8'h00);
    chk("R1 gates", {6'b0, gate_int_en, gate_main_en}, 8'h02);
    chk("R1 pads", {6'b0, xtal_en, extclk_en}, 8'h00);

    for (int i = 0; i < NVEC; i++) begin
      wr(VEC[i][19:17], VEC[i][16:9], VEC[i][8]);
      rd(VEC[i][19:17], v);
      chk($sformatf("vec%0d R2/R4/R5", i), v, VEC[i][7:0]);
    end
    // R3 crystal pad enabled once stop cleared
    chk("R3 xtal pads", {5'b0, xtal_en, extclk_en, amp_hi}, 8'h04);

    // R6 request pending before threshold 2^(3+2)=32 osc cycles
    wr(3'd3, 8'h01, 1'b1);
    repeat (10) @(negedge clk);
    chk("R6 pending gate", {7'b0, gate_main_en}, 8'h00);
    rd(3'd3, v); chk("R6 pending sel", v, 8'h01);
    wait_main(1'b1, 300, n);
    chk("R6 switched", {6'b0, gate_int_en, gate_main_en}, 8'h01);
    rd(3'd4, v); chk("R6 status at switch", v & 8'h07, 8'h07);
    rd(3'd3, v); chk("R6 active", v, 8'h03);

    // R9 stop ignored while main active
    wr(3'd2, 8'h01, 1'b1);
    rd(3'd2, v); chk("R9 stop ignored", v, 8'h00);
    chk("R9 xtal kept", {7'b0, xtal_en}, 8'h01);
    repeat (80) @(negedge clk);
    rd(3'd4, v); chk("R4 status saturated", v, 8'h0F);
    rd(3'd5, v); chk("R4 status high", v, 8'h00);

    // R10 back to internal
    wr(3'd3, 8'h00, 1'b1);
    wait_main(1'b0, 50, n);
    @(negedge clk);
    chk("R10 internal", {6'b0, gate_int_en, gate_main_en}, 8'h02);

    // R9 stop now accepted, status cleared
    wr(3'd2, 8'h01, 1'b1);
    repeat (3) @(negedge clk);
    rd(3'd4, v); chk("R9 status cleared", v, 8'h00);
    chk("R3 xtal off", {7'b0, xtal_en}, 8'h00);

    // R7 external input: no wait on status (index 3 = 64 cycles)
    do_reset();
    wr(3'd0, 8'h07, 1'b1);
    wr(3'd1, 8'h03, 1'b1);
    wr(3'd2, 8'h00, 1'b1);
    chk("R3 ext pads", {5'b0, xtal_en, extclk_en, amp_hi}, 8'h02);
    wr(3'd3, 8'h01, 1'b1);
    wait_main(1'b1, 20, n);
    chk("R7 ext switched", {7'b0, gate_main_en}, 8'h01);
    rd(3'd4, v); chk("R7 threshold not reached", v & 8'h08, 8'h00);

    // R11 no pin function: never granted
    do_reset();
    wr(3'd0, 8'h01, 1'b1);
    wr(3'd2, 8'h00, 1'b1);
    wr(3'd3, 8'h01, 1'b1);
    repeat (150) @(negedge clk);
    chk("R11 no grant", {6'b0, gate_int_en, gate_main_en}, 8'h02);
    rd(3'd3, v); chk("R11 sel pending", v, 8'h01);
    chk("R11 pads off", {6'b0, xtal_en, extclk_en}, 8'h00);

    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule